// File: doc/BRIEF.md
# Instruction Queue Tag Tracker

This block follows comparator matches through a three-entry instruction prefetch queue. Each comparator has a mode bit. With the bit clear, a match on a fetched opcode is an event in the same cycle. With the bit set, the match only marks that opcode. The mark travels with the opcode through the queue, and the event fires only when the opcode leaves the queue head to execute. A flush discards every queued opcode together with its marks, so thrown-away opcodes never produce an event. In tagged mode the comparator address must therefore be the address of an opcode.

Events from all comparators are merged by fixed priority into a small arm-and-trigger sequencer. The sequencer has three waiting steps and a tracing state. Reaching the tracing state starts tracing. The block then counts stored trace lines. When the programmed number of lines has been stored, it raises a one-cycle breakpoint request and returns to idle. No breakpoint can be requested before tracing has finished.

Opcodes enter on a valid/ready stream and leave from the head on a second valid/ready stream. A producer holds `in_valid`, `in_data` and `in_match` steady until `in_ready` is high. The head stays on `out_data` until `out_ready` is taken. `flush` holds both handshakes off in its cycle.

Top module: `iq_tag_tracker`

## Requirements
- R1: After reset, `seq_state` reads 0 (idle), `out_valid`, `tracing` and `brk_req` are low, and `in_ready` is high.
- R2: The queue holds up to 3 opcodes. `in_ready` is low while it is full. Opcodes leave in the order they were accepted. An unaccepted head keeps `out_data` stable.
- R3: A comparator whose mode bit is 0 and which matches on an accepted push gives an event in that cycle, so `seq_state` changes at the next edge. It stores no tag, so that opcode gives no `tag_hit` when it executes.
- R4: A comparator whose mode bit is 1 and which matches on an accepted push causes no event at fetch. The opcode's `tag_hit` bit for that comparator is high exactly in the cycle the opcode is popped from the head, and the event acts at that edge.
- R5: While `flush` is high, `in_ready` and `out_valid` are low. After the flush the queue is empty and every stored tag is gone, so later opcodes give no `tag_hit`.
- R6: The event actions are: comparator 0 enters tracing, comparator 1 advances one step, comparator 2 returns to step 1. When several events occur in one cycle, the lowest comparator index wins, whether the event is immediate or a tag hit.
- R7: `seq_state` encodes idle=0, steps 1..3 as 1..3, and tracing=4. An `arm` pulse in idle moves to step 1. Events in idle have no effect.
- R8: Advancing from step 3 enters tracing. `tracing` is high exactly while `seq_state` is 4.
- R9: In tracing, each `line_stored` pulse counts one line, and events are ignored. The pulse that makes the count reach `trace_len` (or the first pulse if `trace_len` is 0) returns the sequencer to idle at that edge, with `brk_req` high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start the sequencer from idle |
| cmp_tag_mode | input | 3 | Per-comparator mode: 1 tag at fetch, 0 immediate |
| flush | input | 1 | Discard all queued opcodes and tags |
| in_valid | input | 1 | Fetched opcode present |
| in_ready | output | 1 | Queue accepts the fetched opcode |
| in_data | input | 16 | Fetched opcode |
| in_match | input | 3 | Comparator matches for the fetched opcode |
| out_valid | output | 1 | Head opcode present |
| out_ready | input | 1 | Head opcode executes this cycle |
| out_data | output | 16 | Head opcode |
| tag_hit | output | 3 | Tags of the head opcode, high in its pop cycle |
| line_stored | input | 1 | One trace line stored |
| trace_len | input | 8 | Number of lines in a tracing session |
| seq_state | output | 3 | Sequencer state code |
| tracing | output | 1 | Tracing session active |
| brk_req | output | 1 | One-cycle breakpoint request at session end |

## Verification
A tag left in the wrong queue slot shows up as `tag_hit` on a different opcode, or as a missing one, in the cycle that opcode is popped. A wrong transition shows on `seq_state` one edge after the event. A wrong priority choice or a wrong action shows in that same cycle. A wrong line count shows as `brk_req` and the return to idle arriving one or more `line_stored` pulses too early or too late.

// File: rtl/iqtt_pkg.sv
package iqtt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_S1    = 3'd1,
    ST_S2    = 3'd2,
    ST_S3    = 3'd3,
    ST_TRACE = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_TRACE   = 2'd1,
    ACT_NEXT    = 2'd2,
    ACT_RESTART = 2'd3
  } act_e;
endpackage

// File: rtl/iqtt_queue.sv
module iqtt_queue #(
  parameter int DEPTH = 3,
  parameter int DW    = 16,
  parameter int NCMP  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic [NCMP-1:0] in_tags,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic [NCMP-1:0] out_tags,
  output logic            push_fire,
  output logic            pop_fire
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   wr_idx;
  logic [DW-1:0]   q_data [DEPTH];
  logic [NCMP-1:0] q_tag  [DEPTH];

  assign in_ready  = (cnt != CW'(DEPTH)) && !flush;
  assign out_valid = (cnt != '0) && !flush;
  assign push_fire = in_valid && in_ready;
  assign pop_fire  = out_valid && out_ready;
  assign wr_idx    = cnt - CW'(pop_fire);
  assign out_data  = q_data[0];
  assign out_tags  = q_tag[0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt <= '0;
    else cnt <= cnt + CW'(push_fire) - CW'(pop_fire);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_data[i] <= '0;
          q_tag[i]  <= '0;
        end else if (flush) begin
          q_tag[i]  <= '0;
        end else if (push_fire && wr_idx == CW'(i)) begin
          q_data[i] <= in_data;
          q_tag[i]  <= in_tags;
        end else if (pop_fire) begin
          q_data[i] <= q_data[i+1];
          q_tag[i]  <= q_tag[i+1];
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_data[i] <= '0;
          q_tag[i]  <= '0;
        end else if (flush) begin
          q_tag[i]  <= '0;
        end else if (push_fire && wr_idx == CW'(i)) begin
          q_data[i] <= in_data;
          q_tag[i]  <= in_tags;
        end else if (pop_fire) begin
          q_tag[i]  <= '0;
        end
      end
    end
  end

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> flush || (out_valid && $stable(out_data)));
  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);
endmodule

// File: rtl/iqtt_evt.sv
module iqtt_evt
  import iqtt_pkg::*;
#(
  parameter int NCMP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_fire,
  input  logic [NCMP-1:0] in_match,
  input  logic [NCMP-1:0] tag_mode,
  input  logic [NCMP-1:0] hit_tags,
  output act_e            act
);
  logic [NCMP-1:0] evt;

  function automatic act_e act_of(int k);
    if (k == 0) return ACT_TRACE;
    if (k == NCMP - 1 && NCMP > 2) return ACT_RESTART;
    return ACT_NEXT;
  endfunction

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign evt[k] = (push_fire && in_match[k] && !tag_mode[k]) || hit_tags[k];
  end

  always_comb begin
    act = ACT_NONE;
    for (int k = NCMP - 1; k >= 0; k--) begin
      if (evt[k]) act = act_of(k);
    end
  end

  // R6
  top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> act == ACT_TRACE);
endmodule

// File: rtl/iqtt_seq.sv
module iqtt_seq
  import iqtt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  act_e             act,
  input  logic             line_stored,
  input  logic [CNT_W-1:0] trace_len,
  output seq_st_e          st,
  output logic             tracing,
  output logic             brk_req
);
  logic [CNT_W-1:0] lines;
  logic             last_line;

  assign last_line = ({1'b0, lines} + (CNT_W+1)'(1)) >= {1'b0, trace_len};
  assign tracing   = (st == ST_TRACE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lines   <= '0;
      brk_req <= 1'b0;
    end else begin
      brk_req <= 1'b0;
      unique case (st)
        ST_IDLE: if (arm) st <= ST_S1;
        ST_S1, ST_S2, ST_S3: begin
          lines <= '0;
          unique case (act)
            ACT_TRACE:   st <= ST_TRACE;
            ACT_NEXT:    st <= (st == ST_S3) ? ST_TRACE : seq_st_e'(st + 3'd1);
            ACT_RESTART: st <= ST_S1;
            default:     st <= st;
          endcase
        end
        ST_TRACE: if (line_stored) begin
          if (last_line) begin
            st      <= ST_IDLE;
            brk_req <= 1'b1;
          end else begin
            lines <= lines + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
  // R9
  brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(st) == ST_TRACE && st == ST_IDLE);
  // R8
  trace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tracing) |-> $past(st) inside {ST_S1, ST_S2, ST_S3});
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE && !arm |=> st == ST_IDLE);
endmodule

// File: rtl/iq_tag_tracker.sv
module iq_tag_tracker
  import iqtt_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 16,
  parameter int NCMP  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [NCMP-1:0]  cmp_tag_mode,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [NCMP-1:0]  in_match,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [NCMP-1:0]  tag_hit,
  input  logic             line_stored,
  input  logic [CNT_W-1:0] trace_len,
  output logic [2:0]       seq_state,
  output logic             tracing,
  output logic             brk_req
);
  logic [NCMP-1:0] head_tags;
  logic            push_fire;
  logic            pop_fire;
  act_e            act;
  seq_st_e         st;

  iqtt_queue #(.DEPTH(DEPTH), .DW(DW), .NCMP(NCMP)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_tags(in_match & cmp_tag_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tags(head_tags), .push_fire(push_fire), .pop_fire(pop_fire)
  );

  assign tag_hit = pop_fire ? head_tags : '0;

  iqtt_evt #(.NCMP(NCMP)) u_evt (
    .clk(clk), .rst_n(rst_n), .push_fire(push_fire), .in_match(in_match),
    .tag_mode(cmp_tag_mode), .hit_tags(tag_hit), .act(act)
  );

  iqtt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .act(act),
    .line_stored(line_stored), .trace_len(trace_len),
    .st(st), .tracing(tracing), .brk_req(brk_req)
  );

  assign seq_state = st;

  // R4
  hit_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_hit) |-> out_valid && out_ready);
  // R5
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready && !out_valid);
endmodule

// File: tb/iq_tag_tracker_bench.sv
module iq_tag_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm;
  logic [2:0]  cmp_tag_mode;
  logic        flush;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic [2:0]  in_match;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;
  logic [2:0]  tag_hit;
  logic        line_stored;
  logic [7:0]  trace_len;
  logic [2:0]  seq_state;
  logic        tracing;
  logic        brk_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  iq_tag_tracker u_iq_tag_tracker (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cmp_tag_mode(cmp_tag_mode),
    .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_match(in_match), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .tag_hit(tag_hit),
    .line_stored(line_stored), .trace_len(trace_len),
    .seq_state(seq_state), .tracing(tracing), .brk_req(brk_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    arm = 0; flush = 0; in_valid = 0; in_data = '0; in_match = '0;
    out_ready = 0; line_stored = 0;
  endtask

  task automatic do_reset();
    idle_in();
    cmp_tag_mode = '0; trace_len = 8'd1;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic do_arm();
    arm = 1; tick(); arm = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", seq_state, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 tracing", tracing, 0);
    chk("R1 brk", brk_req, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_fifo();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_data = 16'hA0 + 16'(i); tick();
    end
    in_valid = 1; in_data = 16'hFF; #1;
    chk("R2 full in_ready", in_ready, 0);
    tick(); in_valid = 0;
    chk("R2 head held", out_data, 16'hA0);
    for (int i = 0; i < 3; i++) begin
      out_ready = 1; #1;
      chk("R2 order", out_data, 16'hA0 + 32'(i));
      tick();
    end
    out_ready = 0;
    chk("R2 drained", out_valid, 0);
  endtask

  task automatic t_imm();
    do_reset();
    in_valid = 1; in_match = 3'b010; tick(); idle_in();
    chk("R7 ignored idle", seq_state, 0);
    out_ready = 1; tick(); out_ready = 0;
    do_arm();
    chk("R7 arm", seq_state, 1);
    in_valid = 1; in_match = 3'b010; tick(); idle_in();
    chk("R3 immediate advance", seq_state, 2);
    out_ready = 1; #1;
    chk("R3 no tag stored", tag_hit, 0);
    tick(); out_ready = 0;
    chk("R3 state kept", seq_state, 2);
  endtask

  task automatic t_tag();
    do_reset();
    cmp_tag_mode = 3'b010;
    do_arm();
    in_valid = 1; in_data = 16'h11; in_match = 3'b010; tick();
    in_data = 16'h22; in_match = 3'b000; tick(); idle_in();
    chk("R4 no fetch event", seq_state, 1);
    out_ready = 1; #1;
    chk("R4 hit at pop", tag_hit, 3'b010);
    tick();
    chk("R4 advance at pop", seq_state, 2);
    #1;
    chk("R4 next opcode clean", tag_hit, 0);
    tick(); out_ready = 0;
    chk("R4 state after clean pop", seq_state, 2);
  endtask

  task automatic t_flush();
    do_reset();
    cmp_tag_mode = 3'b010;
    do_arm();
    in_valid = 1; in_match = 3'b010; tick(); tick(); idle_in();
    flush = 1; in_valid = 1; out_ready = 1; #1;
    chk("R5 in_ready blocked", in_ready, 0);
    chk("R5 out_valid blocked", out_valid, 0);
    tick(); idle_in();
    chk("R5 empty", out_valid, 0);
    in_valid = 1; in_match = 3'b000; tick(); idle_in();
    out_ready = 1; #1;
    chk("R5 no stale hit", tag_hit, 0);
    tick(); out_ready = 0;
    chk("R5 state kept", seq_state, 1);
  endtask

  task automatic t_prio();
    do_reset(); do_arm();
    in_valid = 1; in_match = 3'b111; tick(); idle_in();
    chk("R6 c0 wins", seq_state, 4);
    chk("R8 tracing", tracing, 1);
    do_reset(); do_arm();
    in_valid = 1; in_match = 3'b110; out_ready = 1; tick();
    chk("R6 c1 over c2", seq_state, 2);
    in_match = 3'b100; tick(); idle_in();
    chk("R6 c2 restart", seq_state, 1);
    do_reset(); cmp_tag_mode = 3'b001; do_arm();
    in_valid = 1; in_match = 3'b001; tick();
    chk("R6 tag pending", seq_state, 1);
    in_match = 3'b100; out_ready = 1; #1;
    chk("R6 tag hit c0", tag_hit, 3'b001);
    tick(); idle_in();
    chk("R6 tag c0 beats imm c2", seq_state, 4);
  endtask

  task automatic t_steps_trace();
    do_reset(); do_arm();
    trace_len = 8'd3;
    out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_match = 3'b010; tick();
      chk("R8 step", seq_state, 32'(i + 2));
    end
    idle_in();
    chk("R8 tracing from step3", tracing, 1);
    in_valid = 1; in_match = 3'b100; out_ready = 1; tick(); idle_in();
    chk("R9 events ignored", seq_state, 4);
    for (int i = 0; i < 2; i++) begin
      line_stored = 1; tick(); line_stored = 0;
      chk("R9 no early brk", brk_req, 0);
      chk("R9 still tracing", tracing, 1);
    end
    tick();
    chk("R9 idle gap no count", brk_req, 0);
    line_stored = 1; tick(); line_stored = 0;
    chk("R9 brk", brk_req, 1);
    chk("R9 idle", seq_state, 0);
    chk("R9 tracing off", tracing, 0);
    tick();
    chk("R9 brk one cycle", brk_req, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fifo();
    t_imm();
    t_tag();
    t_flush();
    t_prio();
    t_steps_trace();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule